// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the programming port of an eight-line interrupt controller. A byte-wide write/read port with one address bit carries two kinds of traffic. The first is a short initialization sequence that sets the vector base and the operating options. The second is a set of run-time commands: end-of-service, priority rotation, register select, poll request and special mask. The block holds the mask, in-service state, vector base, rotation offset and mode flags, and it presents them to the neighbouring request and acknowledge logic.

The request register is not held here. It arrives on `req_in` from the edge detection logic. In-service bits are set by the acknowledge logic through `svc_set`, and they are cleared here by end-of-service commands. Non-specific end-of-service commands clear the in-service line of highest priority. Priority rotates: the line equal to the rotation offset ranks first, and the ranking then rises through the line numbers, wrapping after line 7.

Top module: `ic_cmd_port`

## Requirements
- R1: A write to address 0 with data bit 4 set starts initialization. It clears mask, in-service, vector base, rotation offset and every mode flag, enters the base step, and remembers data bit 0 as "mode word follows". This clear takes priority over every other update in the same cycle.
- R2: In the base step, a write to address 1 stores the data with bits 2:0 forced to zero as `vec_base` and moves to the skip step.
- R3: In the skip step, a write to address 1 ignores its data. It moves to the mode step if "mode word follows" was set, otherwise to normal operation.
- R4: In the mode step, a write to address 1 sets special nesting from data bit 4 and auto end-of-service from data bit 1, then returns to normal operation.
- R5: In normal operation, a write to address 1 loads the mask. A read at address 1 returns the mask.
- R6: A write to address 0 with bit 4 clear and bit 3 set is a control word. Bit 2 set raises the poll flag. When bit 6 is set, bit 5 becomes the special mask flag. When bit 1 is set, bit 0 becomes the read select. Fields whose enable bit is clear keep their value.
- R7: Other address-0 writes take bits 7:5 as an operation code. Codes 0 and 4 load the rotate-on-auto-end flag from bit 7.
- R8: Code 1 clears the in-service bit of highest priority. Code 5 does the same and also sets the rotation offset to that line plus one, modulo 8. When no in-service bit is set, both leave all state unchanged.
- R9: Code 3 clears in-service bit data[2:0]. Code 6 sets the offset to data[2:0] plus one, modulo 8. Code 7 clears in-service bit data[2:0] and sets the offset to that line plus one, modulo 8.
- R10: A read at address 0 returns the in-service register when read select is 1, and `req_in` when read select is 0.
- R11: Bits set on `svc_set` are added to the in-service register at the next edge. A set wins over a clear of the same bit in that cycle.
- R12: Operation code 2 changes no state.
- R13: A cycle with `rd_en` high and no write clears the poll flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, clears all state |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, consumes a pending poll |
| addr | input | 1 | Port address (0 = command, 1 = data) |
| wdata | input | DATA_W | Write data |
| req_in | input | LINES | Current request register from edge detection |
| svc_set | input | LINES | In-service bits to set on acknowledge |
| rdata | output | DATA_W | Read data, combinational from `addr` and state |
| vec_base | output | DATA_W | Vector base, low three bits zero |
| rot_offset | output | LINE_W | Line that currently ranks first |
| auto_eoi | output | 1 | Auto end-of-service mode |
| rot_on_aeoi | output | 1 | Rotate on auto end-of-service |
| spec_nest | output | 1 | Special nesting mode |
| spec_mask | output | 1 | Special mask mode |
| poll_pend | output | 1 | Poll requested, not yet consumed |

## Verification
Every write, `svc_set` pulse and read strobe takes effect at the single rising edge that samples it. Stored state and every output register therefore show the new value one cycle after the stimulus. `rdata` is combinational from `addr` and that state, with no extra delay. The bench drives each stimulus on a falling edge and withdraws it on the next falling edge. It then moves `addr` to the register under test and samples one time unit later, which is exactly one rising edge after the stimulus. Same-cycle collisions are driven in one cycle and read in the next: an initialization word with an acknowledge, and a specific clear with an acknowledge of the same line.

// File: rtl/ic_cmd_pkg.sv
package ic_cmd_pkg;

   // Bit positions of the command byte that a neighbour decodes
   localparam int INIT_BIT  = 4;
   localparam int CTL_BIT   = 3;
   localparam int BASE_CLR  = 3;

   typedef enum logic [1:0] {
      STEP_RUN  = 2'd0,
      STEP_BASE = 2'd1,
      STEP_SKIP = 2'd2,
      STEP_MODE = 2'd3
   } init_step_e;

   typedef enum logic [2:0] {
      OP_ROTA_LO  = 3'd0,
      OP_NS_EOI   = 3'd1,
      OP_NOP      = 3'd2,
      OP_SP_EOI   = 3'd3,
      OP_ROTA_HI  = 3'd4,
      OP_NS_ROT   = 3'd5,
      OP_SET_PRIO = 3'd6,
      OP_SP_ROT   = 3'd7
   } ocw_op_e;

   typedef struct packed {
      logic       init_start;
      logic       fourth;
      logic       ctl;
      logic       poll_set;
      logic       rsel_wr;
      logic       rsel_val;
      logic       smask_wr;
      logic       smask_val;
      ocw_op_e    op;
      logic       rot_val;
      logic [2:0] line;
      logic       nest_val;
      logic       aeoi_val;
   } dec_t;

endpackage

// File: rtl/ic_prio_find.sv
module ic_prio_find #(
   parameter int LINES = 8,
   parameter int IMPL  = 0,
   localparam int LINE_W = $clog2(LINES)
) (
   input  logic [LINES-1:0]  vec,
   input  logic [LINE_W-1:0] offs,
   output logic              found,
   output logic [LINE_W-1:0] line
);

   assign found = |vec;

   generate
      if (IMPL == 0) begin : g_rotate
         // Rotate so the first-ranked line sits at bit 0, then pick lowest set bit
         logic [2*LINES-1:0] dbl;
         logic [LINES-1:0]   rot;
         logic [LINE_W-1:0]  kk;
         always_comb begin
            dbl = {vec, vec};
            rot = dbl[offs +: LINES];
            kk  = '0;
            for (int k = LINES - 1; k >= 0; k--) begin
               if (rot[k]) kk = LINE_W'(k);
            end
            line = kk + offs;
         end
      end else begin : g_scan
         // Walk lines in ranking order, last hit in the descending walk wins
         always_comb begin
            line = '0;
            for (int k = LINES - 1; k >= 0; k--) begin
               logic [LINE_W-1:0] idx;
               idx = offs + LINE_W'(k);
               if (vec[idx]) line = idx;
            end
         end
      end
   endgenerate

   always_comb begin
      if (found) begin
         AST_PRIO_HIT: assert (vec[line]); // R8
      end
   end

endmodule

// File: rtl/ic_cmd_decode.sv
module ic_cmd_decode
   import ic_cmd_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] data,
   output dec_t              dec
);

   always_comb begin
      dec.init_start = data[INIT_BIT];
      dec.fourth     = data[0];
      dec.ctl        = !data[INIT_BIT] && data[CTL_BIT];
      dec.poll_set   = data[2];
      dec.rsel_wr    = data[1];
      dec.rsel_val   = data[0];
      dec.smask_wr   = data[6];
      dec.smask_val  = data[5];
      dec.op         = ocw_op_e'(data[7:5]);
      dec.rot_val    = data[7];
      dec.line       = data[2:0];
      dec.nest_val   = data[4];
      dec.aeoi_val   = data[1];
   end

endmodule

// File: rtl/ic_cmd_port.sv
module ic_cmd_port
   import ic_cmd_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int LINES     = 8,
   parameter int PRIO_IMPL = 0,
   localparam int LINE_W   = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic              addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [LINES-1:0]  req_in,
   input  logic [LINES-1:0]  svc_set,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] vec_base,
   output logic [LINE_W-1:0] rot_offset,
   output logic              auto_eoi,
   output logic              rot_on_aeoi,
   output logic              spec_nest,
   output logic              spec_mask,
   output logic              poll_pend
);

   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("ic_cmd_port: DATA_W must be at least 8");
      end
      if (LINES < 2 || LINES > 8 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
         $error("ic_cmd_port: LINES must be 2, 4 or 8");
      end
      if (PRIO_IMPL < 0 || PRIO_IMPL > 1) begin : g_bad_impl
         $error("ic_cmd_port: PRIO_IMPL must be 0 or 1");
      end
   endgenerate

   init_step_e        step;
   logic              fourth;
   logic [LINES-1:0]  mask;
   logic [LINES-1:0]  isr;
   logic              rsel;

   dec_t              dec;
   logic              wr_cmd;
   logic              init_wr;
   logic              ctl_wr;
   logic              op_wr;
   logic              data_wr;
   logic [LINE_W-1:0] op_line;
   logic              hit;
   logic [LINE_W-1:0] hit_line;
   logic [LINES-1:0]  isr_clr;
   logic              offs_wr;
   logic [LINE_W-1:0] offs_nxt;

   ic_cmd_decode #(
      .DATA_W (DATA_W)
   ) u_decode (
      .data (wdata),
      .dec  (dec)
   );

   ic_prio_find #(
      .LINES (LINES),
      .IMPL  (PRIO_IMPL)
   ) u_prio (
      .vec   (isr),
      .offs  (rot_offset),
      .found (hit),
      .line  (hit_line)
   );

   assign wr_cmd  = wr_en && !addr;
   assign init_wr = wr_cmd && dec.init_start;
   assign ctl_wr  = wr_cmd && dec.ctl;
   assign op_wr   = wr_cmd && !dec.init_start && !dec.ctl;
   assign data_wr = wr_en && addr;
   assign op_line = dec.line[LINE_W-1:0];

   // End-of-service and rotation decode
   always_comb begin
      isr_clr  = '0;
      offs_wr  = 1'b0;
      offs_nxt = rot_offset;
      if (op_wr) begin
         unique case (dec.op)
            OP_NS_EOI, OP_NS_ROT: begin
               if (hit) begin
                  isr_clr[hit_line] = 1'b1;
                  if (dec.op == OP_NS_ROT) begin
                     offs_wr  = 1'b1;
                     offs_nxt = hit_line + LINE_W'(1);
                  end
               end
            end
            OP_SP_EOI: isr_clr[op_line] = 1'b1;
            OP_SP_ROT: begin
               isr_clr[op_line] = 1'b1;
               offs_wr  = 1'b1;
               offs_nxt = op_line + LINE_W'(1);
            end
            OP_SET_PRIO: begin
               offs_wr  = 1'b1;
               offs_nxt = op_line + LINE_W'(1);
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || init_wr) begin
         step        <= rst_n ? STEP_BASE : STEP_RUN;
         fourth      <= rst_n ? dec.fourth : 1'b0;
         mask        <= '0;
         isr         <= '0;
         rsel        <= 1'b0;
         vec_base    <= '0;
         rot_offset  <= '0;
         auto_eoi    <= 1'b0;
         rot_on_aeoi <= 1'b0;
         spec_nest   <= 1'b0;
         spec_mask   <= 1'b0;
         poll_pend   <= 1'b0;
      end else begin
         isr <= (isr & ~isr_clr) | svc_set;
         if (rd_en) poll_pend <= 1'b0;
         if (offs_wr) rot_offset <= offs_nxt;
         if (ctl_wr) begin
            if (dec.poll_set) poll_pend <= 1'b1;
            if (dec.rsel_wr)  rsel      <= dec.rsel_val;
            if (dec.smask_wr) spec_mask <= dec.smask_val;
         end
         if (op_wr && (dec.op == OP_ROTA_LO || dec.op == OP_ROTA_HI)) begin
            rot_on_aeoi <= dec.rot_val;
         end
         if (data_wr) begin
            unique case (step)
               STEP_RUN:  mask <= wdata[LINES-1:0];
               STEP_BASE: begin
                  vec_base <= {wdata[DATA_W-1:BASE_CLR], {BASE_CLR{1'b0}}};
                  step     <= STEP_SKIP;
               end
               STEP_SKIP: step <= fourth ? STEP_MODE : STEP_RUN;
               STEP_MODE: begin
                  spec_nest <= dec.nest_val;
                  auto_eoi  <= dec.aeoi_val;
                  step      <= STEP_RUN;
               end
               default: step <= STEP_RUN;
            endcase
         end
      end
   end

   always_comb begin
      if (addr)      rdata = DATA_W'(mask);
      else if (rsel) rdata = DATA_W'(isr);
      else           rdata = DATA_W'(req_in);
   end

   AST_INIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !addr && wdata[INIT_BIT]) |=> (mask == '0 && isr == '0 && rot_offset == '0 && step == STEP_BASE)); // R1
   AST_BASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr && step == STEP_BASE) |=> (step == STEP_SKIP && vec_base[BASE_CLR-1:0] == '0)); // R2
   AST_SKIP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr && step == STEP_SKIP) |=> (step == ($past(fourth) ? STEP_MODE : STEP_RUN))); // R3
   AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr && step == STEP_RUN) |=> (mask == $past(wdata[LINES-1:0]))); // R5
   AST_SP_EOI_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !addr && !wdata[INIT_BIT] && !wdata[CTL_BIT] && wdata[7:5] == 3'd3 && svc_set == '0)
      |=> !isr[$past(wdata[LINE_W-1:0])]); // R9
   AST_SVC_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_set != '0 && !(wr_en && !addr && wdata[INIT_BIT])) |=> ((isr & $past(svc_set)) == $past(svc_set))); // R11
   AST_POLL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en) |=> !poll_pend); // R13

endmodule

// File: tb/test_ic_cmd_port.sv
`timescale 1ns/1ps
module test_ic_cmd_port;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       wr_en, rd_en, addr;
   logic [7:0] wdata, req_in, svc_set;
   logic [7:0] rdata, vec_base;
   logic [2:0] rot_offset;
   logic       auto_eoi, rot_on_aeoi, spec_nest, spec_mask, poll_pend;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   ic_cmd_port i_ic_cmd_port (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .rd_en       (rd_en),
      .addr        (addr),
      .wdata       (wdata),
      .req_in      (req_in),
      .svc_set     (svc_set),
      .rdata       (rdata),
      .vec_base    (vec_base),
      .rot_offset  (rot_offset),
      .auto_eoi    (auto_eoi),
      .rot_on_aeoi (rot_on_aeoi),
      .spec_nest   (spec_nest),
      .spec_mask   (spec_mask),
      .poll_pend   (poll_pend)
   );

   // Row: kind(2) 0=write 1=svc pulse 2=read strobe | addr | data | svc | check addr | obs sel | expected
   // obs sel: 0 = rdata, 1 = vec_base, 2 = {offset[2:0], aeoi, rot_on_aeoi, nest, smask, poll}
   localparam int NV = 31;
   localparam logic [29:0] TBL [NV] = '{
      {2'd0, 1'b0, 8'h11, 8'h00, 1'b1, 2'd0, 8'h00},
      {2'd0, 1'b1, 8'h47, 8'h00, 1'b0, 2'd1, 8'h40},
      {2'd0, 1'b1, 8'h00, 8'h00, 1'b0, 2'd2, 8'h00},
      {2'd0, 1'b1, 8'h12, 8'h00, 1'b0, 2'd2, 8'h14},
      {2'd0, 1'b1, 8'h5A, 8'h00, 1'b1, 2'd0, 8'h5A},
      {2'd0, 1'b0, 8'h0B, 8'h00, 1'b0, 2'd0, 8'h00},
      {2'd1, 1'b0, 8'h00, 8'h28, 1'b0, 2'd0, 8'h28},
      {2'd0, 1'b0, 8'h20, 8'h00, 1'b0, 2'd0, 8'h20},
      {2'd1, 1'b0, 8'h00, 8'h81, 1'b0, 2'd0, 8'hA1},
      {2'd0, 1'b0, 8'hA0, 8'h00, 1'b0, 2'd2, 8'h34},
      {2'd2, 1'b0, 8'h00, 8'h00, 1'b0, 2'd0, 8'hA0},
      {2'd0, 1'b0, 8'hE5, 8'h00, 1'b0, 2'd0, 8'h80},
      {2'd2, 1'b0, 8'h00, 8'h00, 1'b0, 2'd2, 8'hD4},
      {2'd1, 1'b0, 8'h00, 8'h02, 1'b0, 2'd0, 8'h82},
      {2'd0, 1'b0, 8'h20, 8'h00, 1'b0, 2'd0, 8'h02},
      {2'd0, 1'b0, 8'h63, 8'h00, 1'b0, 2'd0, 8'h02},
      {2'd0, 1'b0, 8'h61, 8'h00, 1'b0, 2'd0, 8'h00},
      {2'd0, 1'b0, 8'hA0, 8'h00, 1'b0, 2'd2, 8'hD4},
      {2'd0, 1'b0, 8'hC2, 8'h00, 1'b0, 2'd2, 8'h74},
      {2'd0, 1'b0, 8'h80, 8'h00, 1'b0, 2'd2, 8'h7C},
      {2'd0, 1'b0, 8'h00, 8'h00, 1'b0, 2'd2, 8'h74},
      {2'd0, 1'b0, 8'h40, 8'h00, 1'b0, 2'd2, 8'h74},
      {2'd0, 1'b0, 8'h0C, 8'h00, 1'b0, 2'd2, 8'h75},
      {2'd2, 1'b0, 8'h00, 8'h00, 1'b0, 2'd2, 8'h74},
      {2'd0, 1'b0, 8'h68, 8'h00, 1'b0, 2'd2, 8'h76},
      {2'd0, 1'b0, 8'h0A, 8'h00, 1'b0, 2'd0, 8'h3C},
      {2'd0, 1'b0, 8'h48, 8'h00, 1'b0, 2'd2, 8'h74},
      {2'd0, 1'b0, 8'h10, 8'h00, 1'b0, 2'd2, 8'h00},
      {2'd0, 1'b1, 8'h08, 8'h00, 1'b0, 2'd1, 8'h08},
      {2'd0, 1'b1, 8'hFF, 8'h00, 1'b0, 2'd2, 8'h00},
      {2'd0, 1'b1, 8'h33, 8'h00, 1'b1, 2'd0, 8'h33}
   };

   function automatic string row_tag(int i);
      case (i)
         0, 27:              return "R1 init clear";
         1, 28:              return "R2 vector base";
         2, 29, 30:          return "R3 skip step";
         3:                  return "R4 mode word";
         4:                  return "R5 mask load";
         5, 22, 24, 26:      return "R6 control word";
         6, 8, 13:           return "R11 service set";
         7, 9, 10, 14, 17:   return "R8 non-specific end";
         11, 12, 15, 16, 18: return "R9 specific end / set priority";
         19, 20:             return "R7 rotate-on-auto flag";
         21:                 return "R12 code 2 no-op";
         23:                 return "R13 read drops poll";
         25:                 return "R10 request read";
         default:            return "R?";
      endcase
   endfunction

   function automatic logic [7:0] observe(logic [1:0] sel);
      case (sel)
         2'd0:    return rdata;
         2'd1:    return vec_base;
         default: return {rot_offset, auto_eoi, rot_on_aeoi, spec_nest, spec_mask, poll_pend};
      endcase
   endfunction

   task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   // Drive one stimulus cycle, then park addr on the register to inspect
   task automatic run_op(logic w, logic r, logic a, logic [7:0] d, logic [7:0] s, logic ca);
      @(negedge clk);
      wr_en   = w;
      rd_en   = r;
      addr    = a;
      wdata   = d;
      svc_set = s;
      @(negedge clk);
      wr_en   = 1'b0;
      rd_en   = 1'b0;
      svc_set = '0;
      addr    = ca;
      #1;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog (all requirements): actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      rst_n   = 1'b0;
      wr_en   = 1'b0;
      rd_en   = 1'b0;
      addr    = 1'b0;
      wdata   = '0;
      svc_set = '0;
      req_in  = 8'h3C;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // Reset state
      addr = 1'b1; #1;
      check("R5 reset mask", rdata, 8'h00);
      addr = 1'b0; #1;
      check("R10 reset request read", rdata, 8'h3C);
      check("R1 reset flags", observe(2'd2), 8'h00);
      check("R2 reset base", vec_base, 8'h00);

      for (int i = 0; i < NV; i++) begin
         logic [29:0] e;
         e = TBL[i];
         run_op(e[29:28] == 2'd0, e[29:28] == 2'd2, e[27], e[26:19], e[18:11], e[10]);
         check(row_tag(i), observe(e[9:8]), e[7:0]);
      end

      // R10: request read follows req_in with a different pattern
      req_in = 8'hC3;
      addr = 1'b0; #1;
      check("R10 request pattern", rdata, 8'hC3);

      // R1 / R11: init in the same cycle as an acknowledge leaves in-service empty
      run_op(1'b1, 1'b0, 1'b0, 8'h11, 8'hFF, 1'b0);
      run_op(1'b1, 1'b0, 1'b0, 8'h0B, 8'h00, 1'b0);
      check("R1 init beats service set", rdata, 8'h00);

      // R11: set of line 4 wins over specific clear of line 4 in the same cycle
      run_op(1'b1, 1'b0, 1'b0, 8'h64, 8'h10, 1'b0);
      check("R11 set beats clear", rdata, 8'h10);

      // R4: finish the sequence with auto end-of-service only
      run_op(1'b1, 1'b0, 1'b1, 8'h00, 8'h00, 1'b0);
      run_op(1'b1, 1'b0, 1'b1, 8'h00, 8'h00, 1'b0);
      run_op(1'b1, 1'b0, 1'b1, 8'h02, 8'h00, 1'b1);
      check("R4 auto end only", observe(2'd2), 8'h10);
      run_op(1'b1, 1'b0, 1'b1, 8'hA5, 8'h00, 1'b1);
      check("R5 mask after mode word", rdata, 8'hA5);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule